// File: doc/BRIEF.md
# Nested-Translation TLB with Granule Retry

This block is a small fully associative translation cache for an IOMMU that can run one stage of translation or two stages (nested). Every slot stores a tag and a result. The tag is the address-space id, the virtual-machine id, the aligned input region, the granule code and the table level. The result is the aligned output address, the region mask and two 2-bit permissions, one per stage. A page-table walker outside the block fills slots through the insert port. Slots are replaced in round-robin order. One pulse of the invalidate input empties the whole cache.

A lookup first probes with the stage-1 granule. If the cache holds more than one matching slot, the slot with the lowest level number (the largest region) is chosen. If the probe misses, the request is nested and the stage-2 granule is different, the block probes a second time with the stage-2 granule. That second probe costs exactly one more cycle, and `req_ready` is low during that cycle. A hit is checked against both stored permissions. A write fault names the stage that denied the write. Two counters record how many lookups hit and how many missed.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid, `hit_count` and `miss_count` are zero, `rsp_valid` is low and `req_ready` is high. A lookup made at that point misses.
- R2: Inserts fill slots 0,1,2,… in order. The ninth insert with 8 slots overwrites slot 0, which held the oldest entry. An invalidate sets the fill position back to slot 0.
- R3: A lookup that hits on the first probe gives `rsp_valid` one cycle after the request is accepted, with `rsp_retried`=0. The output address is the stored aligned output ORed with the request address bits inside the mask. The mask covers the low bits below a shift of 10+2·g + (3−L)·(7+2·g), where g is the granule code (1=4 KiB, 2=16 KiB, 3=64 KiB) and L is the level (0..3).
- R4: A slot matches only when all of these agree with the request: ASID, VMID, granule code, level region, and the address bits above the slot's mask. A mismatch in any one of them misses.
- R5: Suppose the first probe misses, `req_nested`=1 and the two granules differ. Then a second probe with the stage-2 granule gives the response two cycles after the request, with `rsp_retried`=1, and `req_ready` is low in the cycle between.
- R6: If the request is not nested, or the two granules are equal, a miss is reported one cycle after the request and no retry is made.
- R7: When several slots match, the slot with the lowest level number wins. Among slots of the same level, the lowest slot index wins.
- R8: Permissions are 2 bits, with bit 0 = read and bit 1 = write. A write that hits faults unless both stored write bits are set. `rsp_fault_stage` is 0 (stage 1) when the stage-1 write bit is clear, and 1 (stage 2) otherwise.
- R9: An insert with `ins_nested`=0 stores the stage-1 permission into both permission fields, and `ins_perm2` has no effect.
- R10: Each response adds exactly one to `hit_count` (on a hit, including a faulting hit) or to `miss_count` (on a miss). The counters stay still in cycles without a response.
- R11: `inv_all` clears every valid bit in one cycle. If an insert arrives in the same cycle, the invalidate wins.
- R12: A read hit never faults. On a hit, `rsp_perm` is the AND of the two stored permissions. On a miss, `rsp_perm` and `rsp_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Low while a retry probe is in progress |
| req_asid | input | ASID_W | Address-space id of the lookup |
| req_vmid | input | VMID_W | Virtual-machine id of the lookup |
| req_addr | input | ADDR_W | Input address |
| req_write | input | 1 | Access is a write |
| req_nested | input | 1 | Two-stage configuration |
| req_s1_gran | input | 2 | Stage-1 granule code |
| req_s2_gran | input | 2 | Stage-2 granule code |
| ins_valid | input | 1 | Insert a new entry |
| ins_asid | input | ASID_W | Insert ASID |
| ins_vmid | input | VMID_W | Insert VMID |
| ins_addr | input | ADDR_W | Insert input address (aligned in the block) |
| ins_gran | input | 2 | Insert granule code |
| ins_level | input | 2 | Insert table level |
| ins_out | input | ADDR_W | Insert output address (aligned in the block) |
| ins_perm1 | input | 2 | Stage-1 permission |
| ins_perm2 | input | 2 | Stage-2 permission |
| ins_nested | input | 1 | Entry is from a nested walk |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_retried | output | 1 | Result came from the stage-2 granule probe |
| rsp_addr | output | ADDR_W | Translated address |
| rsp_perm | output | 2 | Combined permission |
| rsp_fault | output | 1 | Write permission fault |
| rsp_fault_stage | output | 1 | Faulting stage (0 = stage 1, 1 = stage 2) |
| hit_count | output | COUNT_W | Hit counter |
| miss_count | output | COUNT_W | Miss counter |

## Verification
The assertions assume two things about the inputs. The requester does not expect a new request to be taken while `req_ready` is low. Fewer lookups are made than the counter range, so no counter wraps. The bench serialises its lookups through one task that waits for the response, and it runs only a few dozen lookups. The stimulus overlaps tags only in the deliberate multi-match case. Expected addresses, masks, permissions and the faulting stage come from a shadow table in the bench, which applies the shift formula and the round-robin rule.

// File: rtl/xlat_cache_pkg.sv
// Shared constants and types of the nested-translation cache.
// Assumes granule codes 0..3 and four table levels 0..3.
package xlat_cache_pkg;
    localparam int PAGE_BASE_LOG2 = 10;
    localparam int LAST_LEVEL     = 3;
    localparam int LEVELS         = 4;
    localparam int PERM_R_BIT     = 0;
    localparam int PERM_W_BIT     = 1;

    typedef enum logic {
        STAGE_ONE = 1'b0,
        STAGE_TWO = 1'b1
    } fault_stage_e;
endpackage

// File: rtl/xlat_entry_store.sv
// Slot storage of the translation cache: round-robin insert, invalidate-all.
// Assumes ENTRIES >= 2. The address and output are stored already aligned to
// the region of their granule and level. Data registers have no reset;
// only the valid bits and the fill pointer do.
module xlat_entry_store
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int VMID_W  = 8,
    parameter int ADDR_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inv_all,
    input  logic                             ins_valid,
    input  logic [ASID_W-1:0]                ins_asid,
    input  logic [VMID_W-1:0]                ins_vmid,
    input  logic [ADDR_W-1:0]                ins_addr,
    input  logic [1:0]                       ins_gran,
    input  logic [1:0]                       ins_level,
    input  logic [ADDR_W-1:0]                ins_out,
    input  logic [1:0]                       ins_perm1,
    input  logic [1:0]                       ins_perm2,
    input  logic                             ins_nested,
    output logic [ENTRIES-1:0]               e_valid,
    output logic [ENTRIES-1:0][ASID_W-1:0]   e_asid,
    output logic [ENTRIES-1:0][VMID_W-1:0]   e_vmid,
    output logic [ENTRIES-1:0][1:0]          e_gran,
    output logic [ENTRIES-1:0][1:0]          e_level,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   e_base,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   e_mask,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   e_out,
    output logic [ENTRIES-1:0][1:0]          e_p1,
    output logic [ENTRIES-1:0][1:0]          e_p2
);
    localparam int PTR_W = $clog2(ENTRIES);

    // Low-bit mask of the region covered by one entry of granule g at level l.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [1:0] g, input logic [1:0] l);
        int sh;
        sh = PAGE_BASE_LOG2 + 2 * int'(g)
           + (LAST_LEVEL - int'(l)) * (PAGE_BASE_LOG2 - 3 + 2 * int'(g));
        for (int b = 0; b < ADDR_W; b++) span_mask[b] = (b < sh);
    endfunction

    logic [PTR_W-1:0]  wr_ptr;
    logic [ADDR_W-1:0] ins_mask;
    logic              do_ins;
    logic [1:0]        perm2_eff;

    assign ins_mask  = span_mask(ins_gran, ins_level);
    assign do_ins    = ins_valid && !inv_all;
    assign perm2_eff = ins_nested ? ins_perm2 : ins_perm1;

    // Round-robin fill pointer, returned to slot 0 by an invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all)
            wr_ptr <= '0;
        else if (do_ins)
            wr_ptr <= (wr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : wr_ptr + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic              sel;
        logic              vld;
        logic [ASID_W-1:0] asid_q;
        logic [VMID_W-1:0] vmid_q;
        logic [1:0]        gran_q, lvl_q, p1_q, p2_q;
        logic [ADDR_W-1:0] base_q, mask_q, out_q;

        assign sel = do_ins && (wr_ptr == PTR_W'(i));

        // Valid bit of this slot: set on insert, cleared by reset or invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n || inv_all) vld <= 1'b0;
            else if (sel)          vld <= 1'b1;
        end

        // Tag and result of this slot, written when the pointer selects it.
        always_ff @(posedge clk) begin
            if (sel) begin
                asid_q <= ins_asid;
                vmid_q <= ins_vmid;
                gran_q <= ins_gran;
                lvl_q  <= ins_level;
                mask_q <= ins_mask;
                base_q <= ins_addr & ~ins_mask;
                out_q  <= ins_out & ~ins_mask;
                p1_q   <= ins_perm1;
                p2_q   <= perm2_eff;
            end
        end

        assign e_valid[i] = vld;
        assign e_asid[i]  = asid_q;
        assign e_vmid[i]  = vmid_q;
        assign e_gran[i]  = gran_q;
        assign e_level[i] = lvl_q;
        assign e_base[i]  = base_q;
        assign e_mask[i]  = mask_q;
        assign e_out[i]   = out_q;
        assign e_p1[i]    = p1_q;
        assign e_p2[i]    = p2_q;
    end

    assert_inv_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (e_valid == '0));
    assert_rr_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ins && $countones(e_valid) < ENTRIES)
        |=> ($countones(e_valid) == $past($countones(e_valid)) + 1));
endmodule

// File: rtl/xlat_probe.sv
// One probe of every slot for a single granule. Matches on ASID, VMID,
// granule and region, and picks the lowest level first, then the lowest slot.
// Purely combinational. Assumes the stored base is already aligned.
module xlat_probe #(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int VMID_W  = 8,
    parameter int ADDR_W  = 32,
    parameter int LEVELS  = 4
) (
    input  logic [1:0]                       probe_gran,
    input  logic [ASID_W-1:0]                probe_asid,
    input  logic [VMID_W-1:0]                probe_vmid,
    input  logic [ADDR_W-1:0]                probe_addr,
    input  logic [ENTRIES-1:0]               e_valid,
    input  logic [ENTRIES-1:0][ASID_W-1:0]   e_asid,
    input  logic [ENTRIES-1:0][VMID_W-1:0]   e_vmid,
    input  logic [ENTRIES-1:0][1:0]          e_gran,
    input  logic [ENTRIES-1:0][1:0]          e_level,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   e_base,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   e_mask,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   e_out,
    input  logic [ENTRIES-1:0][1:0]          e_p1,
    input  logic [ENTRIES-1:0][1:0]          e_p2,
    output logic                             hit,
    output logic [ADDR_W-1:0]                hit_addr,
    output logic [1:0]                       hit_p1,
    output logic [1:0]                       hit_p2
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   idx;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = e_valid[i] && (e_asid[i] == probe_asid) && (e_vmid[i] == probe_vmid)
                       && (e_gran[i] == probe_gran)
                       && ((probe_addr & ~e_mask[i]) == e_base[i]);
    end

    // Level-ordered priority: coarsest level first, then the lowest slot index.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int lv = 0; lv < LEVELS; lv++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!hit && match[i] && (e_level[i] == 2'(lv))) begin
                    hit = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end
    end

    assign hit_addr = e_out[idx] | (probe_addr & e_mask[idx]);
    assign hit_p1   = e_p1[idx];
    assign hit_p2   = e_p2[idx];
endmodule

// File: rtl/xlat_perm_check.sv
// Checks an access that hit against both stored permissions and names the
// stage that denied a write. Only writes are checked; a read that hits passes.
module xlat_perm_check
    import xlat_cache_pkg::*;
(
    input  logic         hit,
    input  logic         is_write,
    input  logic [1:0]   perm1,
    input  logic [1:0]   perm2,
    output logic         fault,
    output fault_stage_e stage,
    output logic [1:0]   eff_perm
);
    // Combined permission and fault attribution.
    always_comb begin
        eff_perm = perm1 & perm2;
        fault    = hit && is_write && !(perm1[PERM_W_BIT] && perm2[PERM_W_BIT]);
        stage    = perm1[PERM_W_BIT] ? STAGE_TWO : STAGE_ONE;
    end
endmodule

// File: rtl/xlat_cache.sv
// Nested-translation TLB top. It probes with the stage-1 granule, and with
// the stage-2 granule one cycle later on a nested miss where the granules
// differ. Results and counters are registered. Assumes the requester holds
// off while req_ready is low; a request in that cycle is ignored.
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int VMID_W  = 8,
    parameter int ADDR_W  = 32,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [VMID_W-1:0]  req_vmid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               req_nested,
    input  logic [1:0]         req_s1_gran,
    input  logic [1:0]         req_s2_gran,
    input  logic               ins_valid,
    input  logic [ASID_W-1:0]  ins_asid,
    input  logic [VMID_W-1:0]  ins_vmid,
    input  logic [ADDR_W-1:0]  ins_addr,
    input  logic [1:0]         ins_gran,
    input  logic [1:0]         ins_level,
    input  logic [ADDR_W-1:0]  ins_out,
    input  logic [1:0]         ins_perm1,
    input  logic [1:0]         ins_perm2,
    input  logic               ins_nested,
    input  logic               inv_all,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_retried,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault,
    output logic               rsp_fault_stage,
    output logic [COUNT_W-1:0] hit_count,
    output logic [COUNT_W-1:0] miss_count
);
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0][VMID_W-1:0] e_vmid;
    logic [ENTRIES-1:0][1:0]        e_gran, e_level, e_p1, e_p2;
    logic [ENTRIES-1:0][ADDR_W-1:0] e_base, e_mask, e_out;

    logic              pend;
    logic [ASID_W-1:0] h_asid;
    logic [VMID_W-1:0] h_vmid;
    logic [ADDR_W-1:0] h_addr;
    logic [1:0]        h_gran;
    logic              h_write;

    logic [1:0]        p_gran;
    logic [ASID_W-1:0] p_asid;
    logic [VMID_W-1:0] p_vmid;
    logic [ADDR_W-1:0] p_addr;
    logic              cur_write;
    logic              pr_hit;
    logic [ADDR_W-1:0] pr_addr;
    logic [1:0]        pr_p1, pr_p2, pc_perm;
    logic              pc_fault;
    fault_stage_e      pc_stage;
    logic              start, need_retry, finish;

    xlat_entry_store #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .ins_valid(ins_valid),
        .ins_asid(ins_asid), .ins_vmid(ins_vmid), .ins_addr(ins_addr), .ins_gran(ins_gran),
        .ins_level(ins_level), .ins_out(ins_out), .ins_perm1(ins_perm1), .ins_perm2(ins_perm2),
        .ins_nested(ins_nested), .e_valid(e_valid), .e_asid(e_asid), .e_vmid(e_vmid),
        .e_gran(e_gran), .e_level(e_level), .e_base(e_base), .e_mask(e_mask), .e_out(e_out),
        .e_p1(e_p1), .e_p2(e_p2)
    );

    // Probe inputs: the held request during a retry, the live request otherwise.
    always_comb begin
        p_gran    = pend ? h_gran  : req_s1_gran;
        p_asid    = pend ? h_asid  : req_asid;
        p_vmid    = pend ? h_vmid  : req_vmid;
        p_addr    = pend ? h_addr  : req_addr;
        cur_write = pend ? h_write : req_write;
    end

    xlat_probe #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W), .LEVELS(LEVELS)) u_probe (
        .probe_gran(p_gran), .probe_asid(p_asid), .probe_vmid(p_vmid), .probe_addr(p_addr),
        .e_valid(e_valid), .e_asid(e_asid), .e_vmid(e_vmid), .e_gran(e_gran), .e_level(e_level),
        .e_base(e_base), .e_mask(e_mask), .e_out(e_out), .e_p1(e_p1), .e_p2(e_p2),
        .hit(pr_hit), .hit_addr(pr_addr), .hit_p1(pr_p1), .hit_p2(pr_p2)
    );

    xlat_perm_check u_perm (
        .hit(pr_hit), .is_write(cur_write), .perm1(pr_p1), .perm2(pr_p2),
        .fault(pc_fault), .stage(pc_stage), .eff_perm(pc_perm)
    );

    assign req_ready  = !pend;
    assign start      = req_valid && !pend;
    assign need_retry = start && !pr_hit && req_nested && (req_s2_gran != req_s1_gran);
    assign finish     = pend || (start && !need_retry);

    // Retry flag: set for exactly one cycle after a nested first-probe miss.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= need_retry;
    end

    // Hold the request fields needed by the second probe.
    always_ff @(posedge clk) begin
        if (need_retry) begin
            h_asid  <= req_asid;
            h_vmid  <= req_vmid;
            h_addr  <= req_addr;
            h_gran  <= req_s2_gran;
            h_write <= req_write;
        end
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_retried     <= 1'b0;
            rsp_addr        <= '0;
            rsp_perm        <= '0;
            rsp_fault       <= 1'b0;
            rsp_fault_stage <= 1'b0;
        end else begin
            rsp_valid <= finish;
            if (finish) begin
                rsp_hit         <= pr_hit;
                rsp_retried     <= pend;
                rsp_addr        <= pr_hit ? pr_addr : '0;
                rsp_perm        <= pr_hit ? pc_perm : 2'b00;
                rsp_fault       <= pc_fault;
                rsp_fault_stage <= pc_fault ? pc_stage : STAGE_ONE;
            end
        end
    end

    // Hit and miss counters, one step per finished lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (finish) begin
            if (pr_hit) hit_count  <= hit_count + COUNT_W'(1);
            else        miss_count <= miss_count + COUNT_W'(1);
        end
    end

    assert_retry_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (!pend && rsp_valid && rsp_retried));
    assert_retried_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_retried) |-> $past(!req_ready));
    assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !need_retry) |=> (rsp_valid && !rsp_retried));
    assert_fault_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_hit && !rsp_perm[PERM_W_BIT]));
    assert_read_safe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> $past(cur_write));
    assert_hit_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + COUNT_W'(1)));
    assert_miss_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + COUNT_W'(1)));
    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(hit_count) && $stable(miss_count)));
endmodule

// File: tb/sim_xlat_cache.sv
// Bench for the nested-translation cache. A shadow table is built from the
// requirements and every response and counter is compared with it.
module sim_xlat_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 0, req_write = 0, req_nested = 0, req_ready;
    logic [7:0]  req_asid = 0, req_vmid = 0;
    logic [31:0] req_addr = 0;
    logic [1:0]  req_s1_gran = 0, req_s2_gran = 0;
    logic        ins_valid = 0, ins_nested = 0, inv_all = 0;
    logic [7:0]  ins_asid = 0, ins_vmid = 0;
    logic [31:0] ins_addr = 0, ins_out = 0;
    logic [1:0]  ins_gran = 0, ins_level = 0, ins_perm1 = 0, ins_perm2 = 0;
    logic        rsp_valid, rsp_hit, rsp_retried, rsp_fault, rsp_fault_stage;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_perm;
    logic [15:0] hit_count, miss_count;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_asid(req_asid), .req_vmid(req_vmid), .req_addr(req_addr), .req_write(req_write),
        .req_nested(req_nested), .req_s1_gran(req_s1_gran), .req_s2_gran(req_s2_gran),
        .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_vmid(ins_vmid), .ins_addr(ins_addr),
        .ins_gran(ins_gran), .ins_level(ins_level), .ins_out(ins_out), .ins_perm1(ins_perm1),
        .ins_perm2(ins_perm2), .ins_nested(ins_nested), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retried(rsp_retried), .rsp_addr(rsp_addr),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_fault_stage(rsp_fault_stage),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0, errors = 0;

    // Shadow table
    logic        m_v[8];
    logic [7:0]  m_asid[8], m_vmid[8];
    logic [1:0]  m_gran[8], m_lvl[8], m_p1[8], m_p2[8];
    logic [31:0] m_base[8], m_out[8], m_mask[8];
    int          m_ptr = 0, n_hit = 0, n_miss = 0;

    function automatic logic [31:0] mk_mask(input logic [1:0] g, input logic [1:0] l);
        int sh;
        logic [63:0] m;
        sh = 10 + 2 * int'(g) + (3 - int'(l)) * (7 + 2 * int'(g));
        m = (64'd1 << sh) - 64'd1;
        return m[31:0];
    endfunction

    function automatic int mprobe(input logic [7:0] a, input logic [7:0] v,
                                  input logic [31:0] ad, input logic [1:0] g);
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 8; s++)
                if (m_v[s] && m_asid[s] == a && m_vmid[s] == v && m_gran[s] == g &&
                    m_lvl[s] == 2'(l) && ((ad & ~m_mask[s]) == m_base[s]))
                    return s;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic invalidate();
        @(negedge clk);
        inv_all = 1;
        @(negedge clk);
        inv_all = 0;
        for (int s = 0; s < 8; s++) m_v[s] = 0;
        m_ptr = 0;
    endtask

    task automatic ins(input logic [7:0] a, input logic [7:0] v, input logic [31:0] ad,
                       input logic [1:0] g, input logic [1:0] l, input logic [31:0] o,
                       input logic [1:0] p1, input logic [1:0] p2, input logic nst,
                       input logic with_inv);
        @(negedge clk);
        ins_valid = 1; ins_asid = a; ins_vmid = v; ins_addr = ad; ins_gran = g;
        ins_level = l; ins_out = o; ins_perm1 = p1; ins_perm2 = p2; ins_nested = nst;
        inv_all = with_inv;
        @(negedge clk);
        ins_valid = 0; inv_all = 0;
        if (with_inv) begin
            for (int s = 0; s < 8; s++) m_v[s] = 0;
            m_ptr = 0;
        end else begin
            m_v[m_ptr] = 1; m_asid[m_ptr] = a; m_vmid[m_ptr] = v; m_gran[m_ptr] = g;
            m_lvl[m_ptr] = l; m_mask[m_ptr] = mk_mask(g, l);
            m_base[m_ptr] = ad & ~mk_mask(g, l); m_out[m_ptr] = o & ~mk_mask(g, l);
            m_p1[m_ptr] = p1; m_p2[m_ptr] = nst ? p2 : p1;
            m_ptr = (m_ptr + 1) % 8;
        end
    endtask

    task automatic look(input string tag, input logic [7:0] a, input logic [7:0] v,
                        input logic [31:0] ad, input logic wr, input logic nst,
                        input logic [1:0] g1, input logic [1:0] g2);
        int s;
        logic rt, ef, es;
        logic [31:0] ea;
        logic [1:0] ep;
        s = mprobe(a, v, ad, g1);
        rt = 0;
        if (s < 0 && nst && g1 != g2) begin
            rt = 1;
            s = mprobe(a, v, ad, g2);
        end
        ea = 0; ep = 0; ef = 0; es = 0;
        if (s >= 0) begin
            ea = m_out[s] | (ad & m_mask[s]);
            ep = m_p1[s] & m_p2[s];
            ef = wr && !(m_p1[s][1] && m_p2[s][1]);
            es = ef && m_p1[s][1];
            n_hit++;
        end else n_miss++;
        @(negedge clk);
        req_valid = 1; req_asid = a; req_vmid = v; req_addr = ad; req_write = wr;
        req_nested = nst; req_s1_gran = g1; req_s2_gran = g2;
        @(negedge clk);
        req_valid = 0;
        if (rt) begin
            chk({tag, " R5 ready low"}, 64'(req_ready), 64'd0);
            chk({tag, " R5 no early rsp"}, 64'(rsp_valid), 64'd0);
            @(negedge clk);
        end
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " hit"}, 64'(rsp_hit), 64'(s >= 0));
        chk({tag, " retried"}, 64'(rsp_retried), 64'(rt));
        chk({tag, " addr"}, 64'(rsp_addr), 64'(ea));
        chk({tag, " R12 perm"}, 64'(rsp_perm), 64'(ep));
        chk({tag, " R8 fault"}, 64'(rsp_fault), 64'(ef));
        chk({tag, " R8 stage"}, 64'(rsp_fault_stage), 64'(es));
        chk({tag, " R10 hits"}, 64'(hit_count), 64'(n_hit));
        chk({tag, " R10 misses"}, 64'(miss_count), 64'(n_miss));
    endtask

    initial begin
        for (int s = 0; s < 8; s++) m_v[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 hit_count", 64'(hit_count), 64'd0);
        chk("R1 miss_count", 64'(miss_count), 64'd0);
        look("R1 empty", 8'h01, 8'h02, 32'h1234_5678, 0, 0, 2'd1, 2'd1);

        // R2 R3 R4 R6: nine inserts over granule x level, the first is evicted
        for (int g = 1; g <= 3; g++)
            for (int l = 1; l <= 3; l++)
                ins(8'(16 + g), 8'(32 + l), 32'hC35A_96E7 ^ (32'(g * l) << 16), 2'(g), 2'(l),
                    32'h7B00_0000 + (32'(g) << 20) + (32'(l) << 12), 2'b11, 2'b11, 0, 0);
        for (int g = 1; g <= 3; g++)
            for (int l = 1; l <= 3; l++) begin
                logic [31:0] base, mk;
                base = 32'hC35A_96E7 ^ (32'(g * l) << 16);
                mk = mk_mask(2'(g), 2'(l));
                look("R2 R3 sweep", 8'(16 + g), 8'(32 + l), base ^ (32'h1234_5678 & mk), 0, 0, 2'(g), 2'(g));
                look("R4 asid", 8'(17 + g), 8'(32 + l), base, 0, 0, 2'(g), 2'(g));
                look("R4 vmid", 8'(16 + g), 8'(33 + l), base, 0, 0, 2'(g), 2'(g));
                look("R6 gran", 8'(16 + g), 8'(32 + l), base, 0, 0, 2'(g % 3 + 1), 2'(g));
                if (mk != 32'hFFFF_FFFF)
                    look("R4 region", 8'(16 + g), 8'(32 + l), base ^ (mk + 32'd1), 0, 0, 2'(g), 2'(g));
            end

        // R5 R8 R12: nested retry and write check
        invalidate();
        ins(8'h01, 8'h02, 32'h0004_5000, 2'd1, 2'd3, 32'h8888_8000, 2'b11, 2'b01, 1, 0);
        ins(8'h01, 8'h02, 32'h0007_7000, 2'd1, 2'd3, 32'h9999_9000, 2'b01, 2'b11, 1, 0);
        ins(8'h01, 8'h02, 32'h0009_9000, 2'd1, 2'd3, 32'hAAAA_A000, 2'b11, 2'b11, 1, 0);
        look("R5 R8 stage2 fault", 8'h01, 8'h02, 32'h0004_5123, 1, 1, 2'd3, 2'd1);
        look("R12 read ok", 8'h01, 8'h02, 32'h0004_5123, 0, 1, 2'd3, 2'd1);
        look("R8 stage1 fault", 8'h01, 8'h02, 32'h0007_7FFC, 1, 1, 2'd2, 2'd1);
        look("R8 write ok", 8'h01, 8'h02, 32'h0009_9010, 1, 1, 2'd3, 2'd1);
        look("R5 retry miss", 8'h01, 8'h02, 32'h0050_0000, 0, 1, 2'd2, 2'd1);
        look("R6 same gran", 8'h01, 8'h02, 32'h0050_0000, 0, 1, 2'd1, 2'd1);
        look("R6 not nested", 8'h01, 8'h02, 32'h0004_5000, 0, 0, 2'd3, 2'd1);

        // R9: non-nested inserts ignore the stage-2 permission
        ins(8'h03, 8'h04, 32'h000A_A000, 2'd1, 2'd3, 32'h1000_0000, 2'b11, 2'b00, 0, 0);
        ins(8'h03, 8'h04, 32'h000B_B000, 2'd1, 2'd3, 32'h2000_0000, 2'b01, 2'b11, 0, 0);
        look("R9 perm copy ok", 8'h03, 8'h04, 32'h000A_A004, 1, 0, 2'd1, 2'd1);
        look("R9 perm copy fault", 8'h03, 8'h04, 32'h000B_B004, 1, 0, 2'd1, 2'd1);

        // R7: coarse level wins, then lowest slot
        invalidate();
        ins(8'h05, 8'h06, 32'h0040_3000, 2'd1, 2'd3, 32'h1111_1000, 2'b11, 2'b11, 0, 0);
        ins(8'h05, 8'h06, 32'h0040_0000, 2'd1, 2'd2, 32'h2220_0000, 2'b11, 2'b11, 0, 0);
        ins(8'h05, 8'h06, 32'h0040_0000, 2'd1, 2'd2, 32'h3330_0000, 2'b01, 2'b01, 0, 0);
        look("R7 priority", 8'h05, 8'h06, 32'h0040_3456, 0, 0, 2'd1, 2'd1);
        chk("R7 level addr", 64'(rsp_addr), 64'h2220_3456);

        // R11: invalidate empties the table and beats a same-cycle insert
        ins(8'h07, 8'h08, 32'h0060_0000, 2'd1, 2'd3, 32'h4444_4000, 2'b11, 2'b11, 0, 1);
        look("R11 old gone", 8'h05, 8'h06, 32'h0040_3456, 0, 0, 2'd1, 2'd1);
        look("R11 ins lost", 8'h07, 8'h08, 32'h0060_0000, 0, 0, 2'd1, 2'd1);
        ins(8'h07, 8'h08, 32'h0060_0000, 2'd1, 2'd3, 32'h4444_4000, 2'b11, 2'b11, 0, 0);
        look("R2 R11 refill", 8'h07, 8'h08, 32'h0060_0ABC, 0, 0, 2'd1, 2'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule